// File: doc/BRIEF.md
# Opportunistic instruction buffer fetch unit

This block feeds the issue stage of a small in-order core whose instructions and data live in one single-port synchronous SRAM. The issue stage reads instructions only from a four-halfword buffer held here and never starts a memory access of its own. Every instruction reports, as it completes, whether it used the SRAM. The unit fetches a 32-bit word into the buffer only in a slot that the completing instruction leaves free, and only when the buffer will have room for the whole word. Load/store traffic therefore never contends with instruction fetch, and every stall can be predicted from the instruction stream.

When the issue stage finds the buffer empty, the unit signals a fetch no-op. That pseudo-instruction takes one issue cycle, and its memory slot fetches the next word. A taken branch empties the buffer, drops any word still on its way from the SRAM, and reloads the fetch pointer. If the branch left its slot free, the word at the target is fetched in that same cycle. A target on the upper halfword of a word causes the lower halfword of the fetched word to be dropped. The SRAM returns read data one cycle after the request, and that data is visible to the issue stage in the cycle it arrives.

Top module: `ibuf_fetch_unit`

## Requirements
- R1: After reset the buffer is empty and the fetch pointer equals RESET_VEC. In the first cycle after reset, issue_valid is 0, issue_fnop is 1, and sram_req is 1 with sram_addr equal to RESET_VEC.
- R2: In any cycle with cmpl_valid=1 and cmpl_mem_used=1, sram_req is 0.
- R3: A completion with cmpl_valid=1, cmpl_mem_used=0 and no branch fetches the word at the fetch pointer when at most 2 halfwords remain held after this cycle's pop. The pointer then advances by 4. No fetch is made in a cycle that has neither a completion nor a fetch no-op.
- R4: The buffer never holds more than 4 halfwords. When the halfwords that remain after this cycle's pop exceed 2, a completion makes no fetch.
- R5: When no halfword is available and no branch is taken, issue_fnop is 1 and issue_valid is 0. That cycle makes a fetch unless a completing instruction in the same cycle used memory.
- R6: The halfword in bits [15:0] of a fetched word is at the lower address and is issued before bits [31:16]. Instructions issue in address order.
- R7: sram_rdata is taken one cycle after sram_req. Its halfwords can be issued in that same cycle, with no extra bubble.
- R8: While issue_ready is 0, the offered instruction stays on issue_insn and nothing is removed from the buffer.
- R9: In a cycle with cmpl_valid=1 and cmpl_branch_taken=1, issue_valid and issue_fnop are 0. The buffer and any word arriving in that cycle are discarded. If cmpl_mem_used is 0, the word at the target (address with bits [1:0] cleared) is requested in that same cycle.
- R10: When bit 1 of the branch target is set, the lower halfword of the fetched target word is dropped, so the first instruction issued is the one at the target.
- R11: A taken branch with cmpl_mem_used=1 makes no fetch but still reloads the fetch pointer. The following fetch no-op fetches the target word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | output | 1 | An instruction is offered on issue_insn |
| issue_ready | input | 1 | Issue stage takes the offered instruction |
| issue_insn | output | INSN_W | Oldest buffered instruction |
| issue_fnop | output | 1 | Buffer empty: issue stage runs a fetch no-op this cycle |
| cmpl_valid | input | 1 | An instruction completes this cycle |
| cmpl_mem_used | input | 1 | Completing instruction owns the SRAM slot |
| cmpl_branch_taken | input | 1 | Completing instruction is a taken branch |
| cmpl_branch_target | input | ADDR_W | Byte address of the branch target, halfword aligned |
| sram_req | output | 1 | Instruction fetch request for this slot |
| sram_addr | output | ADDR_W | Word-aligned fetch address |
| sram_rdata | input | WORD_W | Read data, valid one cycle after the request |

## Verification
The bench fills the buffer to exactly the room limit with issue_ready low, so that a design checking room before rather than after the pop, or forgetting the in-flight word, would overfill or fetch one slot early. It runs a stream of memory instructions until the buffer drains, checking that a fetch no-op blocked by a memory completion does not fetch and that the next one does. It takes branches to even and odd targets, a branch whose slot is already used, and a branch while a word is in flight. A design that kept the stale word, fetched from the old pointer, or issued the dropped low halfword would present the wrong instruction or address. A mid-run reset checks that the pointer returns to the reset vector and that the first cycle is a fetch no-op.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    // Which address a fetch in the current slot uses.
    typedef enum logic [1:0] {
        FSRC_NONE = 2'd0,
        FSRC_SEQ  = 2'd1,
        FSRC_TGT  = 2'd2
    } fetch_src_e;

endpackage

// File: rtl/ibuf_hw_queue.sv
// Halfword queue with a bypass view: stored halfwords followed by the
// halfwords of the word arriving from the SRAM this cycle.
module ibuf_hw_queue #(
    parameter int INSN_W = 16,
    parameter int WORD_W = 32,
    parameter int SLOTS  = 4,
    parameter int HPW    = WORD_W / INSN_W,
    parameter int SKIP_W = 1,
    parameter int CNT_W  = $clog2(SLOTS + HPW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [SKIP_W-1:0] in_skip,
    input  logic              pop,
    input  logic              flush,
    output logic [INSN_W-1:0] head,
    output logic [CNT_W-1:0]  fill,
    output logic              room
);

    localparam int VIEW = SLOTS + HPW;

    typedef struct packed {
        logic [SLOTS-1:0][INSN_W-1:0] hw;
        logic [CNT_W-1:0]             cnt;
    } q_state_t;

    q_state_t st_q, st_d;
    logic [VIEW-1:0][INSN_W-1:0] view;
    logic [CNT_W-1:0] left;

    always_comb begin
        int cnt_i;
        int skip_i;
        int src;
        cnt_i  = int'(st_q.cnt);
        skip_i = int'(in_skip);
        view   = '0;
        for (int p = 0; p < SLOTS; p++) begin
            if (p < cnt_i) begin
                view[p] = st_q.hw[p];
            end
        end
        for (int p = 0; p < VIEW; p++) begin
            src = p - cnt_i + skip_i;
            if (in_valid && p >= cnt_i && src < HPW) begin
                view[p] = in_word[src*INSN_W +: INSN_W];
            end
        end
        fill = in_valid ? CNT_W'(cnt_i + HPW - skip_i) : st_q.cnt;
        left = fill - CNT_W'(pop);
        room = (left <= CNT_W'(SLOTS - HPW));
        head = view[0];

        st_d = st_q;
        for (int i = 0; i < SLOTS; i++) begin
            st_d.hw[i] = pop ? view[i+1] : view[i];
        end
        st_d.cnt = flush ? '0 : left;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: never more halfwords visible than the buffer can hold
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(SLOTS));

    // R8: an unconsumed head stays put
    a_r8_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != '0 && !pop && !flush) |=> head == $past(head));

endmodule

// File: rtl/ibuf_fetch_ctrl.sv
// Fetch pointer and slot decision: fetches only in a free memory slot.
module ibuf_fetch_ctrl
    import ibuf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int OFF_W      = 2,
    parameter int HW_LSB     = 1,
    parameter int SKIP_W     = 1,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmpl_valid,
    input  logic              cmpl_mem_used,
    input  logic              branch,
    input  logic [ADDR_W-1:0] branch_target,
    input  logic              fnop,
    input  logic              room,
    output logic              sram_req,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              in_valid,
    output logic [SKIP_W-1:0] in_skip
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] fptr;
        logic              pend;
        logic [SKIP_W-1:0] skip;
    } f_state_t;

    f_state_t    st_q, st_d;
    fetch_src_e  src;
    logic        slot;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] word_a;

    always_comb begin
        st_d   = st_q;
        slot   = cmpl_valid ? !cmpl_mem_used : fnop;
        base   = branch ? branch_target : st_q.fptr;
        word_a = {base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        if (slot && branch) begin
            src = FSRC_TGT;
        end else if (slot && room) begin
            src = FSRC_SEQ;
        end else begin
            src = FSRC_NONE;
        end
        st_d.pend = (src != FSRC_NONE);
        st_d.skip = base[OFF_W-1:HW_LSB];
        st_d.fptr = st_d.pend ? word_a + STEP : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fptr: RESET_VEC, pend: 1'b0, skip: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sram_req  = (src != FSRC_NONE);
    assign sram_addr = word_a;
    assign in_valid  = st_q.pend;
    assign in_skip   = st_q.skip;

    // R2: a memory instruction owns its slot
    a_r2_mem_owns_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_mem_used) |-> !sram_req);

    // R3: back-to-back sequential fetches step by one word
    a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sram_req) && !$past(branch) && sram_req && !branch)
        |-> sram_addr == $past(sram_addr) + STEP);

    // R9: a taken branch in a free slot fetches its target word
    a_r9_target_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (branch && !cmpl_mem_used) |->
        (sram_req && sram_addr[ADDR_W-1:OFF_W] == branch_target[ADDR_W-1:OFF_W]));

    // R11: a branch that cannot fetch still reloads the pointer
    a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (branch && cmpl_mem_used) |=> st_q.fptr == $past(branch_target));

endmodule

// File: rtl/ibuf_fetch_unit.sv
module ibuf_fetch_unit #(
    parameter int ADDR_W    = 32,
    parameter int INSN_W    = 16,
    parameter int WORD_W    = 32,
    parameter int BUF_SLOTS = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              issue_valid,
    input  logic              issue_ready,
    output logic [INSN_W-1:0] issue_insn,
    output logic              issue_fnop,
    input  logic              cmpl_valid,
    input  logic              cmpl_mem_used,
    input  logic              cmpl_branch_taken,
    input  logic [ADDR_W-1:0] cmpl_branch_target,
    output logic              sram_req,
    output logic [ADDR_W-1:0] sram_addr,
    input  logic [WORD_W-1:0] sram_rdata
);

    localparam int HPW        = WORD_W / INSN_W;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int HW_LSB     = $clog2(INSN_W / 8);
    localparam int SKIP_W     = OFF_W - HW_LSB;
    localparam int CNT_W      = $clog2(BUF_SLOTS + HPW + 1);

    logic              branch;
    logic              pop;
    logic              room;
    logic              in_valid;
    logic [SKIP_W-1:0] in_skip;
    logic [CNT_W-1:0]  fill;

    assign branch      = cmpl_valid && cmpl_branch_taken;
    assign issue_valid = (fill != '0) && !branch;
    assign issue_fnop  = (fill == '0) && !branch;
    assign pop         = issue_valid && issue_ready;

    ibuf_hw_queue #(
        .INSN_W (INSN_W),
        .WORD_W (WORD_W),
        .SLOTS  (BUF_SLOTS),
        .HPW    (HPW),
        .SKIP_W (SKIP_W),
        .CNT_W  (CNT_W)
    ) queue_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_word  (sram_rdata),
        .in_skip  (in_skip),
        .pop      (pop),
        .flush    (branch),
        .head     (issue_insn),
        .fill     (fill),
        .room     (room)
    );

    ibuf_fetch_ctrl #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .OFF_W      (OFF_W),
        .HW_LSB     (HW_LSB),
        .SKIP_W     (SKIP_W),
        .RESET_VEC  (RESET_VEC)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmpl_valid    (cmpl_valid),
        .cmpl_mem_used (cmpl_mem_used),
        .branch        (branch),
        .branch_target (cmpl_branch_target),
        .fnop          (issue_fnop),
        .room          (room),
        .sram_req      (sram_req),
        .sram_addr     (sram_addr),
        .in_valid      (in_valid),
        .in_skip       (in_skip)
    );

    // R5: an empty buffer's no-op uses its slot unless memory took it
    a_r5_fnop_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_fnop && !(cmpl_valid && cmpl_mem_used)) |-> sram_req);

    // R7: requested data is offered the next cycle unless a branch flushes
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        sram_req |=> (issue_valid || branch));

endmodule

// File: tb/ibuf_fetch_unit_tb.sv
`timescale 1ns/1ps
module ibuf_fetch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid, issue_ready, issue_fnop;
    logic [15:0] issue_insn;
    logic        cmpl_valid, cmpl_mem_used, cmpl_branch_taken;
    logic [31:0] cmpl_branch_target;
    logic        sram_req;
    logic [31:0] sram_addr, sram_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ibuf_fetch_unit dut_i (
        .clk                (clk),
        .rst_n              (rst_n),
        .issue_valid        (issue_valid),
        .issue_ready        (issue_ready),
        .issue_insn         (issue_insn),
        .issue_fnop         (issue_fnop),
        .cmpl_valid         (cmpl_valid),
        .cmpl_mem_used      (cmpl_mem_used),
        .cmpl_branch_taken  (cmpl_branch_taken),
        .cmpl_branch_target (cmpl_branch_target),
        .sram_req           (sram_req),
        .sram_addr          (sram_addr),
        .sram_rdata         (sram_rdata)
    );

    // SRAM model: the halfword at byte address a holds a[15:0].
    always_ff @(posedge clk) begin
        if (sram_req) sram_rdata <= {sram_addr[15:0] + 16'd2, sram_addr[15:0]};
        else          sram_rdata <= 32'hDEAD_BEEF;
    end

    typedef struct packed {
        logic        cv, mu, br;
        logic [31:0] tgt;
        logic        rdy;
        logic        req;
        logic [31:0] addr;
        logic        val, fnop;
        logic [15:0] insn;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b1,32'h100, 1'b0,1'b1,16'h0,   4'd1},
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h100, 4'd7},
        '{1'b1,1'b0,1'b0,32'h0,  1'b1, 1'b1,32'h104, 1'b1,1'b0,16'h102, 4'd3},
        '{1'b1,1'b0,1'b0,32'h0,  1'b0, 1'b1,32'h108, 1'b1,1'b0,16'h104, 4'd8},
        '{1'b1,1'b0,1'b0,32'h0,  1'b0, 1'b0,32'h0,   1'b1,1'b0,16'h104, 4'd4},
        '{1'b1,1'b1,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h104, 4'd2},
        '{1'b1,1'b0,1'b0,32'h0,  1'b1, 1'b1,32'h10C, 1'b1,1'b0,16'h106, 4'd3},
        '{1'b1,1'b1,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h108, 4'd6},
        '{1'b1,1'b1,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h10A, 4'd2},
        '{1'b1,1'b1,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h10C, 4'd6},
        '{1'b1,1'b1,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h10E, 4'd6},
        '{1'b1,1'b1,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b0,1'b1,16'h0,   4'd5},
        '{1'b1,1'b0,1'b0,32'h0,  1'b1, 1'b1,32'h110, 1'b0,1'b1,16'h0,   4'd5},
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h110, 4'd7},
        '{1'b1,1'b0,1'b1,32'h200,1'b1, 1'b1,32'h200, 1'b0,1'b0,16'h0,   4'd9},
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h200, 4'd9},
        '{1'b1,1'b0,1'b1,32'h306,1'b1, 1'b1,32'h304, 1'b0,1'b0,16'h0,   4'd10},
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h306, 4'd10},
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b1,32'h308, 1'b0,1'b1,16'h0,   4'd5},
        '{1'b1,1'b1,1'b1,32'h402,1'b1, 1'b0,32'h0,   1'b0,1'b0,16'h0,   4'd11},
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b1,32'h400, 1'b0,1'b1,16'h0,   4'd11},
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h402, 4'd11},
        '{1'b1,1'b0,1'b0,32'h0,  1'b1, 1'b1,32'h404, 1'b0,1'b1,16'h0,   4'd3},
        '{1'b1,1'b0,1'b1,32'h500,1'b1, 1'b1,32'h500, 1'b0,1'b0,16'h0,   4'd9},
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h500, 4'd9},
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b0,32'h0,   1'b1,1'b0,16'h502, 4'd6},
        '{1'b0,1'b0,1'b0,32'h0,  1'b1, 1'b1,32'h504, 1'b0,1'b1,16'h0,   4'd5}
    };

    function automatic string tname(input int t);
        case (t)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input int tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tname(tag), what, act, exp);
        end
    endtask

    task automatic drive(input logic cv, input logic mu, input logic br,
                         input logic [31:0] tgt, input logic rdy);
        cmpl_valid         = cv;
        cmpl_mem_used      = mu;
        cmpl_branch_taken  = br;
        cmpl_branch_target = tgt;
        issue_ready        = rdy;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        drive(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Vector table: one row per cycle, inputs then expected outputs.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].cv, VECS[i].mu, VECS[i].br, VECS[i].tgt, VECS[i].rdy);
            #1;
            check(VECS[i].tag, "sram_req", 32'(sram_req), 32'(VECS[i].req));
            if (VECS[i].req) check(VECS[i].tag, "sram_addr", sram_addr, VECS[i].addr);
            check(VECS[i].tag, "issue_valid", 32'(issue_valid), 32'(VECS[i].val));
            check(VECS[i].tag, "issue_fnop", 32'(issue_fnop), 32'(VECS[i].fnop));
            if (VECS[i].val) check(VECS[i].tag, "issue_insn", 32'(issue_insn), 32'(VECS[i].insn));
            @(negedge clk);
        end

        // R1: mid-run reset returns to an empty buffer at the reset vector
        drive(1'b1, 1'b0, 1'b0, 32'h0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
        #1;
        check(1, "issue_valid in reset", 32'(issue_valid), 32'd0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(1, "fnop after reset", 32'(issue_fnop), 32'd1);
        check(1, "valid after reset", 32'(issue_valid), 32'd0);
        check(1, "req after reset", 32'(sram_req), 32'd1);
        check(1, "addr after reset", sram_addr, 32'h100);
        @(negedge clk);
        #1;
        check(7, "first insn after reset", 32'(issue_insn), 32'h100);
        check(7, "valid after refill", 32'(issue_valid), 32'd1);
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule